// File: doc/BRIEF.md
# Receiver Invalid-Level Detector

This block watches a set of serial-line receivers and reports, through an active-low flag, when none of them is carrying a usable signal level. The analog front end is not part of the block. External comparators classify each receiver input into a two-bit level code, and the block works only on those codes. The codes enter through a synchronizer chain, because the comparators switch with no relation to the block's clock.

The flag is filtered asymmetrically. It drops only after every receiver has shown a non-valid level without a break for a long, programmable hold time. It comes back high after a short, programmable release time once any receiver again shows a valid level. A receiver that sits in the band between "quiet" and "valid" is treated as not valid. The detector has no power-state input, so it runs the same whether the interface is forced off, asleep on its own, or forced on. Its output changes the power state only if the system routes it to the powerdown controller's force inputs, which is how cable-detect powerdown is built.

Top module: `rx_invalid_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `invalid_n` is 1. Reset clears both persistence counters and the synchronizer, and the synchronizer resets to the quiet code. With every receiver quiet from reset release onward, `invalid_n` therefore falls exactly `HOLD_CYCLES` clock edges after release.
- R2: Each receiver i uses the code at `rx_level[2i+1:2i]`. Code 2'b00 is quiet, 2'b01 is indeterminate, 2'b10 is valid-positive and 2'b11 is valid-negative. Only codes with bit 1 set count as valid.
- R3: When every receiver presents a non-valid code continuously, `invalid_n` falls on the `SYNC_STAGES + HOLD_CYCLES`-th rising edge counted from the first edge that sees the change. It does not fall on the edge before.
- R4: The indeterminate code counts toward the hold time exactly as the quiet code does.
- R5: If any receiver shows a valid code for even one sampled cycle during the hold window, the count is discarded and a full hold time is needed again.
- R6: While at least one receiver, in any position, presents a valid code, `invalid_n` stays 1 for any length of time.
- R7: While `invalid_n` is 0 and any receiver presents a valid code continuously, `invalid_n` rises on the `SYNC_STAGES + RELEASE_CYCLES`-th edge counted from the first edge that sees the change. It does not rise on the edge before.
- R8: A valid code that lasts fewer sampled cycles than `RELEASE_CYCLES` while `invalid_n` is 0 leaves `invalid_n` at 0, and the release count starts over.
- R9: Once `invalid_n` is 0, continued non-valid codes keep it at 0 for any length of time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 2*NUM_RX | Level codes from the comparators, two bits per receiver, receiver i at bits [2i+1:2i] |
| invalid_n | output | 1 | Low when all receivers have been non-valid for the hold time |

## Verification
A change on `rx_level` reaches the filters only after `SYNC_STAGES` edges. The fall of `invalid_n` is therefore due on edge `SYNC_STAGES + HOLD_CYCLES` after the stimulus, and the rise is due on edge `SYNC_STAGES + RELEASE_CYCLES`. Each timed case in the bench drives its inputs on a falling clock edge. It checks the flag once, on the falling edge after one cycle fewer than the due count, to confirm the old value still holds. It checks again on the falling edge after the due edge, to confirm the new value. Interrupted windows are worked out edge by edge from the cycle the synchronized code changes, so that a restart of the count moves the due edge by exactly the number of edges already counted.

// File: rtl/rxinv_pkg.sv
package rxinv_pkg;

    // Two-bit level code delivered by the comparators for one receiver.
    typedef enum logic [1:0] {
        LVL_QUIET = 2'b00,
        LVL_MID   = 2'b01,
        LVL_POS   = 2'b10,
        LVL_NEG   = 2'b11
    } level_e;

    // Registered state of the top-level flag.
    typedef struct packed {
        logic line_ok;
    } flag_st_t;

    // A level is usable only when it lies outside the indeterminate band.
    function automatic logic lvl_valid(input level_e lvl);
        return (lvl == LVL_POS) || (lvl == LVL_NEG);
    endfunction

endpackage

// File: rtl/rxinv_sync.sv
module rxinv_sync #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_d;
            logic [STAGES-1:0][WIDTH-1:0] stage_q;

            always_comb begin
                stage_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            // Reset to the quiet code so that a reset line reads as non-valid.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign dout = stage_q[STAGES-1];

            // R1
            sync_reset_quiet_chk: assert property (@(posedge clk)
                $rose(rst_n) |-> (stage_q == '0));
        end
    endgenerate

endmodule

// File: rtl/rxinv_classify.sv
module rxinv_classify
    import rxinv_pkg::*;
#(
    parameter int unsigned NUM_RX = 5,
    localparam int unsigned LW    = 2 * NUM_RX
) (
    input  logic [LW-1:0] lvl,
    output logic          any_valid
);

    logic [NUM_RX-1:0] valid_vec;

    generate
        for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
            level_e code;
            assign code         = level_e'(lvl[2*g +: 2]);
            assign valid_vec[g] = lvl_valid(code);
        end
    endgenerate

    assign any_valid = |valid_vec;

endmodule

// File: rtl/rxinv_persist.sv
module rxinv_persist #(
    parameter int unsigned LIMIT   = 16,
    localparam int unsigned CNT_W  = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == LAST);
        hit     = cond && at_last;
        if (!cond || at_last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (st_q.cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/rx_invalid_detect.sv
module rx_invalid_detect
    import rxinv_pkg::*;
#(
    parameter int unsigned NUM_RX         = 5,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned HOLD_CYCLES    = 3000,
    parameter int unsigned RELEASE_CYCLES = 100,
    localparam int unsigned LW            = 2 * NUM_RX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rx_level,
    output logic          invalid_n
);

    logic [LW-1:0] lvl_s;
    logic          any_valid;
    logic          hold_cond, hold_hit;
    logic          rel_cond,  rel_hit;
    flag_st_t      st_d, st_q;

    rxinv_sync #(
        .WIDTH  (LW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_level),
        .dout  (lvl_s)
    );

    rxinv_classify #(
        .NUM_RX (NUM_RX)
    ) u_classify (
        .lvl       (lvl_s),
        .any_valid (any_valid)
    );

    // Long filter: counts only while the flag is high and nothing is valid.
    assign hold_cond = st_q.line_ok && !any_valid;
    // Short filter: counts only while the flag is low and something is valid.
    assign rel_cond  = !st_q.line_ok && any_valid;

    rxinv_persist #(
        .LIMIT (HOLD_CYCLES)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (hold_cond),
        .hit   (hold_hit)
    );

    rxinv_persist #(
        .LIMIT (RELEASE_CYCLES)
    ) u_release (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (rel_cond),
        .hit   (rel_hit)
    );

    always_comb begin
        st_d = st_q;
        if (hold_hit) begin
            st_d.line_ok = 1'b0;
        end else if (rel_hit) begin
            st_d.line_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{line_ok: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign invalid_n = st_q.line_ok;

    // R3
    fall_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(invalid_n) |-> $past(!any_valid));

    // R7
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(invalid_n) |-> $past(any_valid));

    // R6
    stay_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_n && any_valid) |=> invalid_n);

    // R9
    stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!invalid_n && !any_valid) |=> !invalid_n);

    // R7
    filters_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_hit && rel_hit));

endmodule

// File: tb/rx_invalid_detect_test.sv
module rx_invalid_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int NRX  = 5;
    localparam int SYNC = 2;
    localparam int HOLD = 12;
    localparam int REL  = 3;
    localparam int LW   = 2 * NRX;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] rx_level;
    logic          invalid_n;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    rx_invalid_detect #(
        .NUM_RX         (NRX),
        .SYNC_STAGES    (SYNC),
        .HOLD_CYCLES    (HOLD),
        .RELEASE_CYCLES (REL)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_level  (rx_level),
        .invalid_n (invalid_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    typedef struct packed {
        logic [9:0] lv;
        logic [7:0] n;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // Codes: 00 quiet, 01 indeterminate, 10 valid+, 11 valid-.
    localparam int NV = 21;
    localparam vec_t VT [NV] = '{
        '{10'h000, 8'd13, 1'b1, 4'd3},  // R3 one edge early
        '{10'h000, 8'd1,  1'b0, 4'd3},  // R3 due edge
        '{10'h002, 8'd4,  1'b0, 4'd7},  // R7 one edge early
        '{10'h002, 8'd1,  1'b1, 4'd7},  // R7 due edge
        '{10'h155, 8'd13, 1'b1, 4'd4},  // R4 indeterminate counts
        '{10'h155, 8'd1,  1'b0, 4'd4},
        '{10'h0C0, 8'd2,  1'b0, 4'd8},  // R8 short valid burst
        '{10'h155, 8'd10, 1'b0, 4'd8},
        '{10'h200, 8'd4,  1'b0, 4'd7},  // R7 release restarts fully
        '{10'h200, 8'd1,  1'b1, 4'd7},
        '{10'h000, 8'd8,  1'b1, 4'd5},  // R5 partial window
        '{10'h020, 8'd1,  1'b1, 4'd5},  // R5 one valid sample
        '{10'h000, 8'd13, 1'b1, 4'd5},  // R5 full window again
        '{10'h000, 8'd1,  1'b0, 4'd5},
        '{10'h000, 8'd30, 1'b0, 4'd9},  // R9 stays low
        '{10'h008, 8'd4,  1'b0, 4'd7},
        '{10'h008, 8'd1,  1'b1, 4'd7},
        '{10'h054, 8'd13, 1'b1, 4'd2},  // R2 mixed quiet/indeterminate
        '{10'h054, 8'd1,  1'b0, 4'd2},
        '{10'h0C0, 8'd4,  1'b0, 4'd2},  // R2 valid-negative code
        '{10'h0C0, 8'd1,  1'b1, 4'd2}
    };

    task automatic check(input logic exp, input int req, input string what);
        n_checks++;
        if (invalid_n !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, invalid_n, exp);
        end
    endtask

    // Wait n rising edges, then land on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rx_level = 10'h002;
        rst_n    = 1'b0;
        step(2);
        check(1'b1, 1, "flag high in reset");             // R1
        rst_n = 1'b1;
        step(5);
        check(1'b1, 1, "flag high after release");        // R1

        for (int i = 0; i < NV; i++) begin
            rx_level = VT[i].lv;
            step(int'(VT[i].n));
            check(VT[i].exp, int'(VT[i].req), $sformatf("vector %0d", i));
        end

        // R6: each receiver alone keeps the line valid.
        for (int i = 0; i < NRX; i++) begin
            logic [LW-1:0] v;
            v = 10'h155;
            v[2*i +: 2] = (i % 2 == 0) ? 2'b10 : 2'b11;
            rx_level = v;
            step(40);
            check(1'b1, 6, $sformatf("receiver %0d alone valid", i));
        end

        // R1: reset from the low state, then a clean count from release.
        rx_level = 10'h000;
        step(SYNC + HOLD);
        check(1'b0, 3, "low before mid-run reset");       // R3
        rst_n = 1'b0;
        #1;
        check(1'b1, 1, "async reset forces high");        // R1
        step(2);
        rst_n = 1'b1;
        step(HOLD - 1);
        check(1'b1, 1, "counter cleared by reset, early"); // R1
        step(1);
        check(1'b0, 1, "counter cleared by reset, due");   // R1

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule